// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides, byte by byte, whether an I2C slave should answer the address phase of a transfer. A bit-level shifter in front of it delivers each assembled byte with a one-cycle strobe. A flag on that strobe marks the first byte after a START, and a separate pulse reports each START or repeated START. Two CPU-writable registers set the identity of the slave.

The own-address register holds the 7-bit address in bits [7:1] and a General Call enable in bit 0. The extended register holds the low eight bits of a 10-bit address. The two top bits of a 10-bit address come from bits [2:1] of the own-address register.

For every address byte that deserves it, the block requests an acknowledge. It raises a level interrupt on a completed match, which software clears with a pulse. It also reports slave-mode entry, flags a General Call and latches the read/write direction. A 10-bit match takes two bytes. The header byte is acknowledged without an interrupt, and only the matching second byte completes the match. All outputs change on the clock edge that follows the input cycle.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is asserted and after it, both address registers read 00h, and ack_req, irq, slave_act, gcall_flag and rw_bit are 0. The recognizer waits for a first address byte.
- R2: cfg_own_we loads cfg_wdata into the own-address register, and cfg_ext_we loads it into the extended register, on the next edge. Without a write enable a register holds its value. A byte evaluated in the same cycle as a write is compared against the value from before the write.
- R3: A 7-bit match needs four things: a first-flagged byte while waiting, a byte that is not 00h, byte bits [7:3] not equal to 11110b, and byte bits [7:1] equal to own bits [7:1]. On the next edge it pulses ack_req for one cycle, sets irq and slave_act, clears gcall_flag and latches byte bit 0 into rw_bit.
- R4: When own bit 0 is 1, a first-flagged byte of 00h is a General Call. It acknowledges, sets irq, slave_act and gcall_flag, and sets rw_bit to 0. When own bit 0 is 0, the same byte is not acknowledged, raises no interrupt and locks the block.
- R5: A first-flagged byte with bits [7:3] = 11110b is a 10-bit header. If its bits [2:1] equal own bits [2:1], it is acknowledged, irq and slave_act stay unchanged, rw_bit takes byte bit 0, and the block waits for a second byte. Otherwise the header is not acknowledged and the block locks.
- R6: While the block waits for the second 10-bit byte, a byte without the first flag that equals the extended register is acknowledged, sets irq and slave_act, and clears gcall_flag. Any other value is not acknowledged and locks the block. A byte with the first flag is ignored in this state.
- R7: A first byte that does not match locks the block. Once locked, no byte produces ack_req or irq until the next start_det.
- R8: irq is a level. Only a match sets it, and it clears one edge after an irq_clr pulse. A match and irq_clr in the same cycle leave irq set.
- R9: start_det returns the recognizer to waiting for a first byte and clears slave_act and gcall_flag. It does not change irq or rw_bit. A byte strobed in the same cycle as start_det is ignored.
- R10: After slave mode is entered, strobed bytes (the data phase) produce no ack_req. While the block waits for a first byte, bytes without the first flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_own_we | input | 1 | Write strobe for the own-address register |
| cfg_ext_we | input | 1 | Write strobe for the extended address register |
| cfg_wdata | input | 8 | Register write data |
| byte_vld | input | 1 | One-cycle strobe for an assembled byte |
| byte_first | input | 1 | The strobed byte is the first one after a START |
| byte_data | input | 8 | Assembled byte, bit 0 is the last bit received |
| start_det | input | 1 | START or repeated START seen |
| irq_clr | input | 1 | CPU pulse that clears the interrupt |
| own_addr_q | output | 8 | Own-address register readback |
| ext_addr_q | output | 8 | Extended address register readback |
| ack_req | output | 1 | One-cycle request to acknowledge the last byte |
| irq | output | 1 | Match interrupt level |
| slave_act | output | 1 | Slave mode entered |
| gcall_flag | output | 1 | The current match is a General Call |
| rw_bit | output | 1 | Latched read/write direction |

## Verification
The collision that matters is an address match landing in the same cycle as the CPU's irq_clr pulse. The match must win and irq must stay set. The bench forces this directly by pulsing irq_clr together with the strobe of a matching 7-bit byte. The random phase produces more such cases by drawing irq_clr independently of bytes that are biased toward the configured addresses. A second collision is start_det arriving together with a byte strobe, where the byte must be dropped. Both are judged cycle by cycle against a bench-side model of the requirements.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W   = 8;
  localparam int PFX_W    = 5;
  localparam int HI_W     = 2;
  localparam logic [PFX_W-1:0]  TEN_PFX = 5'b11110;
  localparam logic [BYTE_W-1:0] GC_BYTE = '0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEN2  = 2'd1,
    ST_SLAVE = 2'd2,
    ST_LOCK  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic gc_hit;
    logic ten_hit;
    logic sev_hit;
    logic ext_hit;
  } hit_t;
endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg #(
  parameter int W = i2c_am_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_own,
  input  logic         we_ext,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] own_q,
  output logic [W-1:0] ext_q
);
  logic [W-1:0] own_d, ext_d;

  always_comb begin
    own_d = own_q;
    ext_d = ext_q;
    if (we_own) own_d = wdata;
    if (we_ext) ext_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      ext_q <= '0;
    end else begin
      own_q <= own_d;
      ext_q <= ext_d;
    end
  end

  assert_own_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_own |=> $stable(own_q));
  assert_ext_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ext |=> $stable(ext_q));
endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
  import i2c_am_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] byte_data,
  input  logic [W-1:0] own_q,
  input  logic [W-1:0] ext_q,
  output hit_t         hit
);
  logic gc_seen;
  logic ten_hdr;

  always_comb begin
    gc_seen     = (byte_data == GC_BYTE);
    ten_hdr     = (byte_data[W-1 -: PFX_W] == TEN_PFX);
    hit.gc_hit  = gc_seen && own_q[0];
    hit.ten_hit = ten_hdr && (byte_data[HI_W:1] == own_q[HI_W:1]);
    hit.sev_hit = !ten_hdr && !gc_seen && (byte_data[W-1:1] == own_q[W-1:1]);
    hit.ext_hit = (byte_data == ext_q);
  end

  always_comb begin
    assert_one_first_kind_R3: assert ($onehot0({hit.gc_hit, hit.ten_hit, hit.sev_hit}));
  end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic byte_first,
  input  logic byte_lsb,
  input  logic start_det,
  input  logic irq_clr,
  input  hit_t hit,
  output logic ack_req,
  output logic irq,
  output logic slave_act,
  output logic gcall_flag,
  output logic rw_bit
);
  seq_state_e st_q, st_d;
  logic ack_d, irq_d, set_irq, slave_d, gc_d, rw_d;

  always_comb begin
    st_d    = st_q;
    ack_d   = 1'b0;
    set_irq = 1'b0;
    slave_d = slave_act;
    gc_d    = gcall_flag;
    rw_d    = rw_bit;
    if (start_det) begin
      st_d    = ST_IDLE;
      slave_d = 1'b0;
      gc_d    = 1'b0;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_IDLE: begin
          if (byte_first) begin
            if (hit.gc_hit) begin
              ack_d = 1'b1; set_irq = 1'b1; slave_d = 1'b1;
              gc_d  = 1'b1; rw_d = 1'b0; st_d = ST_SLAVE;
            end else if (hit.ten_hit) begin
              ack_d = 1'b1; rw_d = byte_lsb; st_d = ST_TEN2;
            end else if (hit.sev_hit) begin
              ack_d = 1'b1; set_irq = 1'b1; slave_d = 1'b1;
              gc_d  = 1'b0; rw_d = byte_lsb; st_d = ST_SLAVE;
            end else begin
              st_d = ST_LOCK;
            end
          end
        end
        ST_TEN2: begin
          if (!byte_first) begin
            if (hit.ext_hit) begin
              ack_d = 1'b1; set_irq = 1'b1; slave_d = 1'b1;
              gc_d  = 1'b0; st_d = ST_SLAVE;
            end else begin
              st_d = ST_LOCK;
            end
          end
        end
        default: ;
      endcase
    end
    irq_d = set_irq || (irq && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ack_req    <= 1'b0;
      irq        <= 1'b0;
      slave_act  <= 1'b0;
      gcall_flag <= 1'b0;
      rw_bit     <= 1'b0;
    end else begin
      st_q       <= st_d;
      ack_req    <= ack_d;
      irq        <= irq_d;
      slave_act  <= slave_d;
      gcall_flag <= gc_d;
      rw_bit     <= rw_d;
    end
  end

  assert_irq_has_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ack_req);
  assert_gc_in_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_flag |-> slave_act);
  assert_hdr_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TEN2 && $past(st_q) == ST_IDLE) |-> (!$rose(irq) && ack_req));
  assert_lock_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && !start_det) |=> !ack_req);
  assert_irq_fall_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_IDLE && !slave_act && !ack_req));
  assert_slave_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLAVE) |=> !ack_req);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_own_we,
  input  logic              cfg_ext_we,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              byte_vld,
  input  logic              byte_first,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_det,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] own_addr_q,
  output logic [BYTE_W-1:0] ext_addr_q,
  output logic              ack_req,
  output logic              irq,
  output logic              slave_act,
  output logic              gcall_flag,
  output logic              rw_bit
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_i_n;
  hit_t              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_N-1];

  i2c_am_cfg #(.W(BYTE_W)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .we_own(cfg_own_we), .we_ext(cfg_ext_we),
    .wdata(cfg_wdata), .own_q(own_addr_q), .ext_q(ext_addr_q)
  );

  i2c_am_decode #(.W(BYTE_W)) u_dec (
    .byte_data(byte_data), .own_q(own_addr_q), .ext_q(ext_addr_q), .hit(hit)
  );

  i2c_am_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .byte_vld(byte_vld), .byte_first(byte_first),
    .byte_lsb(byte_data[0]), .start_det(start_det), .irq_clr(irq_clr),
    .hit(hit), .ack_req(ack_req), .irq(irq), .slave_act(slave_act),
    .gcall_flag(gcall_flag), .rw_bit(rw_bit)
  );
endmodule

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_own_we = 0, cfg_ext_we = 0, byte_vld = 0, byte_first = 0;
  logic start_det = 0, irq_clr = 0;
  logic [7:0] cfg_wdata = 0, byte_data = 0;
  logic [7:0] own_addr_q, ext_addr_q;
  logic ack_req, irq, slave_act, gcall_flag, rw_bit;

  always #5 clk = ~clk;

  i2c_addr_match dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_own = 0, m_ext = 0;
  int   m_st = 0;
  logic m_ack = 0, m_irq = 0, m_slave = 0, m_gc = 0, m_rw = 0;

  task automatic model(input logic vld, first, input logic [7:0] d,
                       input logic st, clr, weo, wee, input logic [7:0] wd,
                       output string tag);
    logic set;
    set = 0; m_ack = 0; tag = "R10";
    if (st) begin
      m_st = 0; m_slave = 0; m_gc = 0; tag = "R9";
    end else if (vld) begin
      case (m_st)
        0: if (first) begin
             if (d == 8'h00 && m_own[0]) begin
               m_ack = 1; set = 1; m_slave = 1; m_gc = 1; m_rw = 0; m_st = 2; tag = "R4";
             end else if (d[7:3] == 5'b11110) begin
               tag = "R5";
               if (d[2:1] == m_own[2:1]) begin m_ack = 1; m_rw = d[0]; m_st = 1; end
               else m_st = 3;
             end else if (d != 8'h00 && d[7:1] == m_own[7:1]) begin
               m_ack = 1; set = 1; m_slave = 1; m_gc = 0; m_rw = d[0]; m_st = 2; tag = "R3";
             end else begin
               m_st = 3; tag = (d == 8'h00) ? "R4" : "R7";
             end
           end
        1: begin
             tag = "R6";
             if (!first) begin
               if (d == m_ext) begin m_ack = 1; set = 1; m_slave = 1; m_gc = 0; m_st = 2; end
               else m_st = 3;
             end
           end
        3: tag = "R7";
        default: tag = "R10";
      endcase
    end
    if (clr) tag = "R8";
    m_irq = set | (m_irq & ~clr);
    if (weo) begin m_own = wd; tag = "R2"; end
    if (wee) begin m_ext = wd; tag = "R2"; end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    n_chk++;
    if (ack_req !== m_ack) begin bad = 1; $display("FAIL %s ack_req act=%b exp=%b", tag, ack_req, m_ack); end
    if (irq !== m_irq) begin bad = 1; $display("FAIL %s irq act=%b exp=%b", tag, irq, m_irq); end
    if (slave_act !== m_slave) begin bad = 1; $display("FAIL %s slave_act act=%b exp=%b", tag, slave_act, m_slave); end
    if (gcall_flag !== m_gc) begin bad = 1; $display("FAIL %s gcall_flag act=%b exp=%b", tag, gcall_flag, m_gc); end
    if (rw_bit !== m_rw) begin bad = 1; $display("FAIL %s rw_bit act=%b exp=%b", tag, rw_bit, m_rw); end
    if (own_addr_q !== m_own) begin bad = 1; $display("FAIL %s own_addr_q act=%h exp=%h", tag, own_addr_q, m_own); end
    if (ext_addr_q !== m_ext) begin bad = 1; $display("FAIL %s ext_addr_q act=%h exp=%h", tag, ext_addr_q, m_ext); end
    if (bad) n_fail++;
  endtask

  task automatic apply(input logic vld, first, input logic [7:0] d,
                       input logic st, clr, weo, wee, input logic [7:0] wd);
    string tag;
    @(negedge clk);
    byte_vld = vld; byte_first = first; byte_data = d; start_det = st;
    irq_clr = clr; cfg_own_we = weo; cfg_ext_we = wee; cfg_wdata = wd;
    model(vld, first, d, st, clr, weo, wee, wd, tag);
    @(posedge clk); #2;
    compare(tag);
  endtask

  task automatic idle1();
    apply(0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2 compare("R1");                              // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 compare("R1");                              // R1 after release
    // R2 register writes
    apply(0, 0, 8'h00, 0, 0, 1, 0, 8'hA7);
    apply(0, 0, 8'h00, 0, 0, 0, 1, 8'h3C);
    idle1();
    // R3 7-bit write match, then R10 data byte
    apply(0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
    apply(1, 1, 8'hA6, 0, 0, 0, 0, 8'h00);
    apply(1, 0, 8'hA6, 0, 0, 0, 0, 8'h00);
    // R8 clear, then match colliding with clear
    apply(0, 0, 8'h00, 0, 1, 0, 0, 8'h00);
    apply(0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
    apply(1, 1, 8'hA7, 0, 1, 0, 0, 8'h00);
    apply(0, 0, 8'h00, 0, 1, 0, 0, 8'h00);
    // R4 general call enabled, then disabled
    apply(0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
    apply(1, 1, 8'h00, 0, 0, 0, 0, 8'h00);
    apply(0, 0, 8'h00, 1, 1, 1, 0, 8'hA6);
    apply(1, 1, 8'h00, 0, 0, 0, 0, 8'h00);
    apply(1, 1, 8'hA6, 0, 0, 0, 0, 8'h00);         // R7 locked
    // R5 / R6 10-bit
    apply(0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
    apply(1, 1, 8'hF7, 0, 0, 0, 0, 8'h00);
    apply(1, 1, 8'h3C, 0, 0, 0, 0, 8'h00);         // first-flag ignored in TEN2
    apply(1, 0, 8'h3C, 0, 0, 0, 0, 8'h00);
    apply(0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
    apply(1, 1, 8'hF6, 0, 0, 0, 0, 8'h00);
    apply(1, 0, 8'h3D, 0, 0, 0, 0, 8'h00);
    apply(0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
    apply(1, 1, 8'hF2, 0, 0, 0, 0, 8'h00);
    apply(1, 0, 8'h3C, 0, 0, 0, 0, 8'h00);
    // R9 start together with byte
    apply(1, 1, 8'hA6, 1, 0, 0, 0, 8'h00);
    apply(1, 0, 8'hA6, 0, 0, 0, 0, 8'h00);         // R10 non-first in idle
    idle1();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 25)      d = {m_own[7:1], 1'($urandom_range(0, 1))};
      else if (sel < 45) d = {5'b11110, m_own[2:1], 1'($urandom_range(0, 1))};
      else if (sel < 60) d = m_ext;
      else if (sel < 70) d = 8'h00;
      else               d = 8'($urandom);
      apply($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, d,
            $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
            $urandom_range(0, 49) == 0, $urandom_range(0, 49) == 0,
            8'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule